// File: doc/BRIEF.md
# RC5 Infrared Frame Decoder

This block turns the demodulated output of an infrared receiver into RC5 command words. The receiver output is active low and asynchronous. The block brings it into the system clock domain. It measures time in ticks of a 32.768 kHz enable pulse, not with a second clock.

Decoding is edge-relative. The block does not oversample the bi-phase stream. A falling edge on an idle line marks the middle of the first start bit. Each accepted transition starts a wait of three quarters of a bit. At the end of that wait the line level is taken as the next bit. After each sample, a transition of either polarity must appear within half a bit. If none appears, the frame is dropped, an error pulse is raised and the decoder waits for a new frame.

When the fourteenth transition has been timed out, the 12-bit payload is presented with a one-clock strobe. The payload holds the toggle bit, the address and the command. An indicator pin reports whether the command equals a 6-bit match code.

The payload leaves as a strobe without a ready input, so there is no back-pressure. The payload register holds its value until the next complete frame. A consumer that misses the strobe can still read the value for at least one frame time.

Top module: `ir_frame_decoder`

## Requirements
- R1: After reset, `frame_valid`, `frame_error`, `cmd_match` and `frame_data` are all zero. An idle decoder starts a frame only on a falling edge of `ir_rx_n`.
- R2: After each accepted transition, the line level is sampled SAMPLE_TICKS (44) ticks later. A frame whose half-bit is anywhere from 24 to 34 ticks decodes correctly.
- R3: Line encoding at `ir_rx_n`: a bit of value 1 is high for the first half of its period and low for the second half. A bit of value 0 is the reverse. Both start bits are 1.
- R4: Fourteen bits are sent most significant first: two start bits, then the toggle, address and command. `frame_data[11]` holds the toggle, `frame_data[10:6]` the address and `frame_data[5:0]` the command.
- R5: `frame_valid` is high for exactly one clock per complete frame. `frame_data` changes only in that cycle and holds its value otherwise, including across an aborted frame.
- R6: Suppose no transition arrives within HALF_TICKS (29) ticks after a sample. Then `frame_error` pulses for one clock and no `frame_valid` is produced for that frame.
- R7: After a timeout, the partial frame is discarded. The next well-formed frame decodes to its exact payload.
- R8: On the clock after `frame_valid`, `cmd_match` is set if `frame_data[5:0]` equals `match_code` and cleared otherwise. It holds that value between frames.
- R9: `frame_valid` and `frame_error` are never high in the same cycle.
- R10: Transitions at bit boundaries are ignored. A payload made of runs of equal bits, all ones or all zeros, decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-clock pulse at 32.768 kHz |
| ir_rx_n | input | 1 | Active-low receiver output, asynchronous |
| match_code | input | CMD_W | Command value that sets the indicator |
| frame_valid | output | 1 | One-clock strobe when a payload is complete |
| frame_data | output | PAYLOAD_W | Last decoded payload: toggle, address, command |
| frame_error | output | 1 | One-clock pulse when a frame is abandoned |
| cmd_match | output | 1 | Command of the last frame equalled `match_code` |

## Verification
The assertions check every cycle for the following:
- the strobe and the error are single-cycle and never high together;
- the payload register changes only on a strobe;
- the indicator moves only on the clock after a strobe, and then to the correct comparison result.

The timing behaviour can only be shown by the bench scenarios:
- sampling three quarters of a bit after each transition;
- tolerance to stretched and compressed bit periods;
- rejection of boundary transitions;
- the half-bit timeout with a clean restart.

The bench drives whole waveforms for these scenarios and compares each decoded payload against a scoreboard.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_TO_SAMPLE = 2'd1,
    ST_WAIT_EDGE = 2'd2
  } rx_state_e;

endpackage

// File: rtl/ir_rx_sync.sv
module ir_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);

  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
    end else begin
      chain <= {chain[STAGES-1:0], din};
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~chain[STAGES];
  assign fall  = ~level & chain[STAGES];

endmodule

// File: rtl/ir_rx_seq.sv
module ir_rx_seq
  import ir_rx_pkg::*;
#(
  parameter int HALF_TICKS   = 29,
  parameter int SAMPLE_TICKS = 44,
  parameter int FRAME_BITS   = 14,
  parameter int PAYLOAD_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 level,
  input  logic                 rise,
  input  logic                 fall,
  output logic                 valid,
  output logic [PAYLOAD_W-1:0] data,
  output logic                 error
);

  localparam int MAX_TICKS = (SAMPLE_TICKS > HALF_TICKS) ? SAMPLE_TICKS : HALF_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam int BIT_W     = $clog2(FRAME_BITS + 1);

  rx_state_e            state;
  logic [CNT_W-1:0]     tick_cnt;
  logic [BIT_W-1:0]     bits_left;
  logic [PAYLOAD_W-1:0] shreg;

  logic sample_now;
  logic window_out;
  logic last_bit;

  assign sample_now = tick && (tick_cnt == CNT_W'(SAMPLE_TICKS - 1));
  assign window_out = tick && (tick_cnt == CNT_W'(HALF_TICKS - 1));
  assign last_bit   = (bits_left == BIT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      tick_cnt  <= '0;
      bits_left <= BIT_W'(FRAME_BITS);
      shreg     <= '0;
      valid     <= 1'b0;
      error     <= 1'b0;
      data      <= '0;
    end else begin
      valid <= 1'b0;
      error <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (fall) begin
            tick_cnt <= '0;
            state    <= ST_TO_SAMPLE;
          end
        end
        ST_TO_SAMPLE: begin
          if (sample_now) begin
            tick_cnt <= '0;
            if (last_bit) begin
              valid     <= 1'b1;
              data      <= shreg;
              shreg     <= '0;
              bits_left <= BIT_W'(FRAME_BITS);
              state     <= ST_IDLE;
            end else begin
              bits_left <= bits_left - BIT_W'(1);
              shreg     <= {shreg[PAYLOAD_W-2:0], level};
              state     <= ST_WAIT_EDGE;
            end
          end else if (tick) begin
            tick_cnt <= tick_cnt + CNT_W'(1);
          end
        end
        ST_WAIT_EDGE: begin
          if (rise || fall) begin
            tick_cnt <= '0;
            state    <= ST_TO_SAMPLE;
          end else if (window_out) begin
            error     <= 1'b1;
            tick_cnt  <= '0;
            shreg     <= '0;
            bits_left <= BIT_W'(FRAME_BITS);
            state     <= ST_IDLE;
          end else if (tick) begin
            tick_cnt <= tick_cnt + CNT_W'(1);
          end
        end
        default: begin
          state <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/ir_rx_match.sv
module ir_rx_match #(
  parameter int CMD_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [CMD_W-1:0] cmd,
  input  logic [CMD_W-1:0] code,
  output logic             hit
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit <= 1'b0;
    end else if (valid) begin
      hit <= (cmd == code);
    end
  end

endmodule

// File: rtl/ir_frame_decoder.sv
module ir_frame_decoder #(
  parameter int SYNC_STAGES  = 2,
  parameter int HALF_TICKS   = 29,
  parameter int SAMPLE_TICKS = 44,
  parameter int FRAME_BITS   = 14,
  parameter int PAYLOAD_W    = 12,
  parameter int CMD_W        = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 ir_rx_n,
  input  logic [CMD_W-1:0]     match_code,
  output logic                 frame_valid,
  output logic [PAYLOAD_W-1:0] frame_data,
  output logic                 frame_error,
  output logic                 cmd_match
);

  logic line_level;
  logic line_rise;
  logic line_fall;

  ir_rx_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (ir_rx_n),
    .level (line_level),
    .rise  (line_rise),
    .fall  (line_fall)
  );

  ir_rx_seq #(
    .HALF_TICKS   (HALF_TICKS),
    .SAMPLE_TICKS (SAMPLE_TICKS),
    .FRAME_BITS   (FRAME_BITS),
    .PAYLOAD_W    (PAYLOAD_W)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_en),
    .level (line_level),
    .rise  (line_rise),
    .fall  (line_fall),
    .valid (frame_valid),
    .data  (frame_data),
    .error (frame_error)
  );

  ir_rx_match #(
    .CMD_W (CMD_W)
  ) u_match (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (frame_valid),
    .cmd   (frame_data[CMD_W-1:0]),
    .code  (match_code),
    .hit   (cmd_match)
  );

endmodule

// File: rtl/ir_frame_decoder_chk.sv
module ir_frame_decoder_chk #(
  parameter int PAYLOAD_W = 12,
  parameter int CMD_W     = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [CMD_W-1:0]     match_code,
  input logic                 frame_valid,
  input logic [PAYLOAD_W-1:0] frame_data,
  input logic                 frame_error,
  input logic                 cmd_match
);

  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> $stable(frame_data));

  assert_error_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_error |=> !frame_error);

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_valid && frame_error));

  assert_match_moves_after_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_match) |-> $past(frame_valid));

  assert_match_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_valid) |-> (cmd_match == ($past(frame_data[CMD_W-1:0]) == $past(match_code))));

endmodule

bind ir_frame_decoder ir_frame_decoder_chk #(
  .PAYLOAD_W (PAYLOAD_W),
  .CMD_W     (CMD_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .match_code  (match_code),
  .frame_valid (frame_valid),
  .frame_data  (frame_data),
  .frame_error (frame_error),
  .cmd_match   (cmd_match)
);

// File: tb/ir_frame_decoder_test.sv
module ir_frame_decoder_test;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int NOM_HALF   = 29;
  localparam int GAP_TICKS  = 120;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        ir_rx_n = 1'b1;
  logic [5:0]  match_code = 6'd32;
  logic        frame_valid;
  logic [11:0] frame_data;
  logic        frame_error;
  logic        cmd_match;

  typedef struct {
    logic [11:0] data;
    logic        hit;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  int   exp_errs = 0;
  int   seen_errs = 0;
  logic [11:0] last_data = '0;
  logic        last_hit = 1'b0;

  ir_frame_decoder uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .ir_rx_n     (ir_rx_n),
    .match_code  (match_code),
    .frame_valid (frame_valid),
    .frame_data  (frame_data),
    .frame_error (frame_error),
    .cmd_match   (cmd_match)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      repeat (TICK_DIV-1) @(negedge clk);
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(posedge clk);
      while (!tick_en) @(posedge clk);
    end
    #1;
  endtask

  task automatic drive_bit(input logic v, input int half);
    ir_rx_n = v;
    wait_ticks(half);
    ir_rx_n = ~v;
    wait_ticks(half);
  endtask

  // R3 encoding: 1 = high then low, start bits are 1; R4 order MSB first
  task automatic send_frame(input logic [11:0] pl, input int half);
    exp_t e;
    logic [13:0] word;
    word   = {2'b11, pl};
    e.data = pl;
    e.hit  = (pl[5:0] == match_code);
    exp_q.push_back(e);
    for (int i = 13; i >= 0; i--) drive_bit(word[i], half);
    ir_rx_n = 1'b1;
    wait_ticks(GAP_TICKS);
  endtask

  task automatic abort_frame(input logic [11:0] pl, input int nbits);
    logic [13:0] word;
    word = {2'b11, pl};
    exp_errs++;
    for (int i = 13; i > 13 - nbits; i--) drive_bit(word[i], NOM_HALF);
    ir_rx_n = 1'b1;
    wait_ticks(GAP_TICKS + 60);
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (frame_valid && frame_error)
          chk(1'b0, "R9", "valid and error together", 1, 0);
        if (frame_error) seen_errs++;
        if (frame_valid) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R6", "unexpected frame_valid", {20'd0, frame_data}, 0);
          end else begin
            e = exp_q.pop_front();
            chk(frame_data == e.data, "R4", "payload", {20'd0, frame_data}, {20'd0, e.data});
            last_data = e.data;
            @(negedge clk);
            chk(!frame_valid, "R5", "strobe width", {31'd0, frame_valid}, 0);
            chk(cmd_match == e.hit, "R8", "indicator", {31'd0, cmd_match}, {31'd0, e.hit});
            last_hit = e.hit;
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", "run did not finish", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (8) @(posedge clk);
    #1;
    chk(frame_valid == 1'b0, "R1", "reset valid", {31'd0, frame_valid}, 0);
    chk(frame_error == 1'b0, "R1", "reset error", {31'd0, frame_error}, 0);
    chk(frame_data == 12'd0, "R1", "reset data", {20'd0, frame_data}, 0);
    chk(cmd_match == 1'b0, "R1", "reset indicator", {31'd0, cmd_match}, 0);
    rst_n = 1'b1;
    wait_ticks(20);

    // R1 arm on falling edge, R8 match hit
    match_code = 6'd32;
    send_frame({1'b0, 5'd0, 6'd32}, NOM_HALF);
    // R3 mixed bits, miss
    send_frame(12'hA5C, NOM_HALF);
    // R2 compressed and stretched bit periods
    send_frame({1'b1, 5'd7, 6'd32}, 24);
    send_frame(12'h3B5, 34);
    // R10 runs of equal bits
    match_code = 6'd63;
    send_frame(12'hFFF, NOM_HALF);
    match_code = 6'd0;
    send_frame(12'h000, NOM_HALF);
    // R6 timeout, R5 hold across abort
    match_code = 6'd32;
    abort_frame(12'h6E3, 6);
    chk(seen_errs == exp_errs, "R6", "error pulses", seen_errs, exp_errs);
    chk(frame_data == last_data, "R5", "data held after abort", {20'd0, frame_data}, {20'd0, last_data});
    chk(cmd_match == last_hit, "R8", "indicator held after abort", {31'd0, cmd_match}, {31'd0, last_hit});
    // R7 clean restart after timeout
    send_frame(12'h7C1, NOM_HALF);
    send_frame({1'b0, 5'd21, 6'd32}, NOM_HALF);

    chk(exp_q.size() == 0, "R7", "frames outstanding", exp_q.size(), 0);
    chk(seen_errs == exp_errs, "R6", "final error count", seen_errs, exp_errs);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule